// File: doc/BRIEF.md
# Capture/Compare Timer with Pulse Accumulator

A 16-bit free-running counter shared by four channels. Each channel either snapshots the counter when its input shows a chosen edge (capture) or drives its output pin when the counter reaches a programmed value (compare). The counter advances once per tick of a prescaler whose ratio is a power of two from 1 to 128. A separate 16-bit pulse accumulator counts edges on its own input pin.

A channel in compare mode can also toggle its pin whenever the main counter wraps. Together with a compare action, this produces a PWM waveform with the counter period. Software reaches the block through a flat register port with a synchronous write and a combinational read. All events land in one flag register, which is cleared by writing 1 to a bit. Per-bit enables combine the flags into a single interrupt line.

Register map (word addresses): 0 control, 1 counter, 2 flags, 3 interrupt enables, 4 accumulator, 8+n channel n setup, 12+n channel n value. Control bits: [0] run, [3:1] prescale select s (divide by 2^s), [4] accumulator enable, [5] accumulator counts falling edges when 1 and rising edges when 0. Channel setup bits: [0] mode (1 = compare), [1] capture on rising edge, [2] capture on falling edge, [4:3] compare pin action (00 none, 01 toggle, 10 drive 0, 11 drive 1), [5] toggle on counter wrap. Flag and enable bits: [3:0] channel events, [4] counter wrap, [5] accumulator wrap.

Top module: `cc_timer`

## Requirements
- R1: After reset, the counter, the accumulator, all flags, all enables, the compare pins and irq are 0.
- R2: While control bit 0 is set, the counter advances by one on every 2^s-th clock, where s is control[3:1]. While control bit 0 is clear, the counter holds. A write to address 1 loads the counter and restarts the prescaler.
- R3: When the counter passes from 0xFFFF to 0x0000, flag bit 4 is set.
- R4: A channel in capture mode (setup[0]=0) copies the counter into its value register and sets its flag on each input edge selected by setup[1] (rising) and setup[2] (falling). Edges it has not selected change nothing.
- R5: A channel in compare mode sets its flag in the clock where the counter steps onto its value register. In the same clock it applies the pin action in setup[4:3].
- R6: With setup[5] set on a compare channel, the pin toggles when the counter wraps. If a compare action other than none falls on the same clock, that action wins over the toggle.
- R7: With control bit 4 set, the accumulator increments on each edge of pa_in of the polarity chosen by control[5]. With control bit 4 clear, pa_in has no effect.
- R8: An accumulator increment from 0xFFFF wraps it to 0 and sets flag bit 5.
- R9: Writing to address 2 clears each flag bit whose write-data bit is 1.
- R10: irq is high exactly when some flag bit and its matching enable bit (address 3) are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr (combinational) |
| cap_in | input | 4 | Per-channel capture inputs |
| pa_in | input | 1 | Pulse accumulator input |
| cmp_out | output | 4 | Per-channel compare outputs |
| irq | output | 1 | Interrupt request |

## Verification
The prescaler is tried with all eight ratios over the same run length, plus two shorter runs. Together these separate a wrong divide ratio from an off-by-one in the tick position. Compare channels are run with set, toggle and clear actions on distinct match values, so a swapped action encoding or a missed match shows up on a specific pin. Wrap behaviour is tested twice: once with toggle alone and once with a compare set on the wrap clock, which shows whether the action takes priority. Capture is driven with both selected and unselected edges while the counter is held at known values. The accumulator is pulsed while enabled, while disabled, in falling-edge mode, and from 0xFFFF.

// File: rtl/cc_timer.sv
module cc_timer #(
  parameter int CW  = 16,
  parameter int NCH = 4,
  parameter int PW  = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [3:0]     addr,
  input  logic [CW-1:0]  wdata,
  output logic [CW-1:0]  rdata,
  input  logic [NCH-1:0] cap_in,
  input  logic           pa_in,
  output logic [NCH-1:0] cmp_out,
  output logic           irq
);
  localparam int FW = NCH + 2;
  localparam logic [CW-1:0] TOP = {CW{1'b1}};

  logic [5:0]     ctrl;
  logic [CW-1:0]  cnt, pacc;
  logic [PW-1:0]  pre;
  logic [FW-1:0]  flags, ien;
  logic [NCH-1:0] ev, cap_q;
  logic           pa_q;
  logic [5:0]     cfg [NCH];
  logic [CW-1:0]  val [NCH];

  wire [PW-1:0] mask   = ~({PW{1'b1}} << ctrl[3:1]);
  wire          tick   = ctrl[0] && ((pre & mask) == mask);
  wire          ld_cnt = wr_en && addr == 4'd1;
  wire          ld_pa  = wr_en && addr == 4'd4;
  wire          wrap   = tick && !ld_cnt && cnt == TOP;
  wire [CW-1:0] cnt_nx = cnt + 1'b1;
  wire          pa_edg = ctrl[5] ? (pa_q & ~pa_in) : (pa_in & ~pa_q);
  wire          pa_inc = ctrl[4] && pa_edg && !ld_pa;
  wire          pa_wrp = pa_inc && pacc == TOP;
  wire [FW-1:0] clr    = (wr_en && addr == 4'd2) ? wdata[FW-1:0] : '0;

  assign irq = |(flags & ien);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0; cnt <= '0; pre <= '0; pacc <= '0;
      flags <= '0; ien <= '0; pa_q <= 1'b0;
    end else begin
      pa_q  <= pa_in;
      flags <= (flags & ~clr) | {pa_wrp, wrap, ev};
      if (wr_en && addr == 4'd0) ctrl <= wdata[5:0];
      if (wr_en && addr == 4'd3) ien  <= wdata[FW-1:0];
      if (ld_cnt) begin
        cnt <= wdata;
        pre <= '0;
      end else if (ctrl[0]) begin
        pre <= pre + 1'b1;
        if (tick) cnt <= cnt_nx;
      end
      if (ld_pa) pacc <= wdata;
      else if (pa_inc) pacc <= pacc + 1'b1;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    wire rise  = cap_in[i] & ~cap_q[i];
    wire fall  = ~cap_in[i] & cap_q[i];
    wire capt  = !cfg[i][0] && ((cfg[i][1] && rise) || (cfg[i][2] && fall));
    wire match = cfg[i][0] && tick && !ld_cnt && cnt_nx == val[i];
    assign ev[i] = capt | match;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg[i] <= '0; val[i] <= '0; cap_q[i] <= 1'b0; cmp_out[i] <= 1'b0;
      end else begin
        cap_q[i] <= cap_in[i];
        if (wr_en && addr == 4'(8 + i)) cfg[i] <= wdata[5:0];
        if (capt) val[i] <= cnt;
        else if (wr_en && addr == 4'(12 + i)) val[i] <= wdata;
        if (match && cfg[i][4:3] != 2'b00)
          case (cfg[i][4:3])
            2'b01:   cmp_out[i] <= ~cmp_out[i];
            2'b10:   cmp_out[i] <= 1'b0;
            default: cmp_out[i] <= 1'b1;
          endcase
        else if (wrap && cfg[i][0] && cfg[i][5])
          cmp_out[i] <= ~cmp_out[i];
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      4'd0: rdata = CW'(ctrl);
      4'd1: rdata = cnt;
      4'd2: rdata = CW'(flags);
      4'd3: rdata = CW'(ien);
      4'd4: rdata = pacc;
      default:
        if (addr[3] && int'(addr[1:0]) < NCH)
          rdata = addr[2] ? val[addr[1:0]] : CW'(cfg[addr[1:0]]);
    endcase
  end
endmodule

module cc_timer_chk #(
  parameter int CW = 16,
  parameter int FW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [3:0]    addr,
  input logic [5:0]    ctrl,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] pacc,
  input logic [FW-1:0] flags,
  input logic          irq
);
  wire ld_cnt = wr_en && addr == 4'd1;
  wire ld_pa  = wr_en && addr == 4'd4;

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[0] && !ld_cnt) |=> $stable(cnt));
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_cnt |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));
  a_r3_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == {CW{1'b1}} && !ld_cnt) |=> (cnt != '0 || flags[FW-2]));
  a_r8_pa_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (pacc == {CW{1'b1}} && !ld_pa) |=> (pacc != '0 || flags[FW-1]));
  a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flags != '0);
endmodule

bind cc_timer cc_timer_chk #(.CW(CW), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .ctrl(ctrl),
  .cnt(cnt), .pacc(pacc), .flags(flags), .irq(irq)
);

// File: tb/tb_cc_timer.sv
`timescale 1ns/1ps
module tb_cc_timer;
  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, pa_in = 1'b0;
  logic [3:0]  addr = '0, cap_in = '0;
  logic [15:0] wdata = '0, rdata;
  logic [3:0]  cmp_out;
  logic        irq;
  int          tests = 0, fails = 0;
  bit          done = 1'b0;
  logic [15:0] v;

  always #4 clk = ~clk;

  cc_timer dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
                .rdata(rdata), .cap_in(cap_in), .pa_in(pa_in), .cmp_out(cmp_out), .irq(irq));

  // {prescale select, running clocks, expected count}
  localparam int VEC [10][3] = '{
    '{0, 257, 257}, '{1, 257, 128}, '{2, 257, 64}, '{3, 257, 32}, '{4, 257, 16},
    '{5, 257, 8},   '{6, 257, 4},   '{7, 257, 2},  '{3, 20, 2},   '{5, 100, 3}};

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic run_from(logic [15:0] start, int sel, int n);
    wr(4'd1, start);
    wr(4'd0, 16'(sel << 1) | 16'd1);
    repeat (n - 2) @(negedge clk);
    wr(4'd0, 16'(sel << 1));
  endtask

  task automatic pulse();
    @(negedge clk); pa_in = 1'b1;
    @(negedge clk); pa_in = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(4'd1, v); chk("R1 counter", v, 16'h0);
    rd(4'd2, v); chk("R1 flags", v, 16'h0);
    rd(4'd4, v); chk("R1 accumulator", v, 16'h0);
    chk("R1 pins/irq", {11'd0, irq, cmp_out}, 16'h0);

    for (int i = 0; i < 10; i++) begin
      run_from(16'h0, VEC[i][0], VEC[i][1]);
      rd(4'd1, v); chk($sformatf("R2 prescale row %0d", i), v, 16'(VEC[i][2]));
    end
    @(negedge clk); @(negedge clk);
    rd(4'd1, v); chk("R2 held while stopped", v, 16'(VEC[9][2]));

    // R3/R6/R10: wrap with toggle-on-wrap, action none
    wr(4'd8, 16'h21); wr(4'd12, 16'h8000); wr(4'd3, 16'h10);
    run_from(16'hFFFE, 0, 2);
    rd(4'd1, v); chk("R3 wrapped count", v, 16'h0);
    rd(4'd2, v); chk("R3 wrap flag", v, 16'h10);
    chk("R6 toggle on wrap", {15'd0, cmp_out[0]}, 16'h1);
    chk("R10 irq set", {15'd0, irq}, 16'h1);
    wr(4'd2, 16'h3F);
    rd(4'd2, v); chk("R9 write-one clears", v, 16'h0);
    chk("R10 irq cleared", {15'd0, irq}, 16'h0);

    // R6 priority: compare set at 0 together with wrap toggle
    wr(4'd8, 16'h39); wr(4'd12, 16'h0);
    run_from(16'hFFFF, 0, 2);
    chk("R6 action beats toggle", {15'd0, cmp_out[0]}, 16'h1);
    wr(4'd8, 16'h0); wr(4'd2, 16'h3F);

    // R5 compare actions
    wr(4'd9, 16'h19); wr(4'd13, 16'd5);
    wr(4'd10, 16'h09); wr(4'd14, 16'd3);
    run_from(16'h0, 0, 8);
    rd(4'd2, v); chk("R5 match flags", v, 16'h06);
    chk("R5 set and toggle pins", {12'd0, cmp_out}, 16'h7);
    wr(4'd9, 16'h11);
    run_from(16'h0, 0, 8);
    chk("R5 clear and toggle pins", {12'd0, cmp_out}, 16'h1);
    rd(4'd13, v); chk("R5 compare value kept", v, 16'd5);
    wr(4'd2, 16'h3F);

    // R4 capture on ch3
    wr(4'd11, 16'h02); wr(4'd1, 16'h1234);
    @(negedge clk); cap_in[3] = 1'b1; @(negedge clk);
    rd(4'd15, v); chk("R4 rising capture", v, 16'h1234);
    rd(4'd2, v); chk("R4 capture flag", v, 16'h08);
    wr(4'd2, 16'h3F); wr(4'd1, 16'h2222);
    @(negedge clk); cap_in[3] = 1'b0; @(negedge clk);
    rd(4'd15, v); chk("R4 unselected edge ignored", v, 16'h1234);
    rd(4'd2, v); chk("R4 no flag on unselected edge", v, 16'h0);
    wr(4'd11, 16'h06);
    @(negedge clk); cap_in[3] = 1'b1; @(negedge clk);
    rd(4'd15, v); chk("R4 both-edge capture", v, 16'h2222);
    wr(4'd2, 16'h3F);

    // R7/R8 accumulator
    wr(4'd0, 16'h10);
    repeat (3) pulse();
    rd(4'd4, v); chk("R7 rising edges counted", v, 16'd3);
    wr(4'd0, 16'h0);
    repeat (2) pulse();
    rd(4'd4, v); chk("R7 disabled ignores input", v, 16'd3);
    wr(4'd4, 16'hFFFF); wr(4'd0, 16'h10);
    pulse();
    rd(4'd4, v); chk("R8 accumulator wraps", v, 16'h0);
    rd(4'd2, v); chk("R8 accumulator flag", v, 16'h20);
    wr(4'd0, 16'h30);
    @(negedge clk); pa_in = 1'b1; @(negedge clk); @(negedge clk);
    rd(4'd4, v); chk("R7 falling mode ignores rise", v, 16'h0);
    pa_in = 1'b0; @(negedge clk); @(negedge clk);
    rd(4'd4, v); chk("R7 falling edge counted", v, 16'h1);
    wr(4'd3, 16'h20);
    chk("R10 irq from accumulator flag", {15'd0, irq}, 16'h1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule